// File: doc/BRIEF.md
# Video Command Port with Palette and ROM Overlay Control

This block is the write-only command port of a video controller. Every 8-bit write that reaches it is sorted by its two top bits into one of three commands. One loads a palette pointer, one loads a colour code into the entry that pointer names, and one loads a configuration register that holds the display mode and two ROM-disable bits. The fourth code is reserved and has no effect. The palette holds sixteen ink entries and one border entry, each a 5-bit colour code. A pixel pipeline reads an ink through a combinational lookup port, and the border colour is always on its own output.

A configuration write does not switch the display mode at once. The new mode is held pending and moves to the mode output only at the next horizontal flyback, so the mode changes on a line boundary. A small state machine tracks this with two states. `MS_IDLE` means no change is waiting. `MS_PEND` means a legal mode has been written and not yet applied. A legal mode write moves the machine from `MS_IDLE` to `MS_PEND`; this transition is called *arm*. The same write in `MS_PEND` replaces the waiting value and keeps the state; this is *rearm*. When `MS_PEND` sees a flyback cycle with no new write, the mode is applied and the machine returns to `MS_IDLE`; this is *commit*.

The ROM-enable bits steer memory reads. A read in the lowest or highest 16K of the address space is served from ROM while that half is enabled. Writes always go to RAM. An external disable input turns all internal ROM reads off. A configuration bit sends a one-cycle clear pulse to the line interrupt divider, which lies outside this block.

Top module: `vid_cmd_port`

## Requirements
- R1: Bits 7:6 of a write select the command: 2'b00 loads the pointer, 2'b01 loads a colour, 2'b10 loads the configuration register, and 2'b11 changes no pointer, palette, ROM, mode or clear state.
- R2: A pointer write stores bits 4:0. When bit 4 is 1 the border entry is selected and bits 3:0 are ignored; otherwise bits 3:0 select an ink. The pointer does not change on a colour write, so there is no auto-increment.
- R3: A colour write stores bits 4:0 into the selected entry. From the cycle after the write, the new code is seen on `border_colour`, or on `pix_colour` while `pix_ink` names that ink.
- R4: In a configuration write, bit 2 = 1 disables the lower ROM half and bit 3 = 1 disables the upper half. `rom_lo_en` and `rom_hi_en` show the inverted bits from the cycle after the write.
- R5: A configuration write with bit 4 = 1 drives `irq_div_clr` high for exactly the one cycle after the write. The pulse is never high at any other time.
- R6: A configuration write with a legal mode in bits 1:0 (arm or rearm) is applied by commit. `video_mode` takes the newest pending value in the cycle after the first `hflyback`-high cycle that has no mode write and follows the write. Otherwise `video_mode` holds.
- R7: Mode value 3 is illegal. A configuration write carrying it leaves both the pending and the shown mode unchanged, but its ROM and clear bits still act.
- R8: After reset `video_mode` is 0, both ROM halves are enabled, `border_colour` is 0, the pointer selects ink 0, `irq_div_clr` is low and no mode change is pending.
- R9: `rd_from_rom` is 1 only when `mem_rd` is 1 and either address bits 15:14 are 2'b00 with the lower half enabled, or they are 2'b11 with the upper half enabled. It is 0 for every write (`mem_rd` = 0).
- R10: While `ext_rom_off` is 1, `rd_from_rom` is 0 whatever the ROM-enable bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command write strobe, one cycle per write |
| wr_data | input | 8 | Command byte |
| hflyback | input | 1 | High during horizontal flyback |
| pix_ink | input | 4 | Ink index for the palette lookup |
| pix_colour | output | 5 | Colour code of ink `pix_ink` |
| border_colour | output | 5 | Border colour code |
| video_mode | output | 2 | Mode currently applied |
| mem_addr | input | 16 | Memory access address |
| mem_rd | input | 1 | 1 = read access, 0 = write access |
| ext_rom_off | input | 1 | External disable of internal ROM |
| rom_lo_en | output | 1 | Lower ROM half enabled |
| rom_hi_en | output | 1 | Upper ROM half enabled |
| rd_from_rom | output | 1 | This access is served from ROM |
| irq_div_clr | output | 1 | One-cycle clear pulse to the line interrupt divider |

## Verification
The hardest case to reach is rearm: a second mode write that lands while an earlier one is still pending. A mode write in the same cycle as a flyback, which must not commit, is just as hard. Random writes with a sparse flyback rate make long pending windows. Directed sequences then place a rearm, an illegal mode, and a write that meets flyback exactly on the edge of the commit cycle. A bench model predicts the shown mode every cycle.

// File: rtl/vid_cmd_pkg.sv
package vid_cmd_pkg;

    typedef enum logic [1:0] {
        CMD_PTR = 2'b00,
        CMD_INK = 2'b01,
        CMD_CFG = 2'b10,
        CMD_RSV = 2'b11
    } cmd_e;

    typedef enum logic {
        MS_IDLE = 1'b0,
        MS_PEND = 1'b1
    } msync_e;

    localparam int          MODE_W   = 2;
    localparam logic [1:0]  MODE_BAD = 2'b11;

    typedef struct packed {
        logic ptr_ld;
        logic ink_ld;
        logic cfg_ld;
        logic mode_ok;
        logic div_clr;
    } wr_dec_t;

endpackage

// File: rtl/vid_cmd_decode.sv
module vid_cmd_decode
    import vid_cmd_pkg::*;
(
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output wr_dec_t    dec
);
    cmd_e cmd;

    always_comb begin
        cmd = cmd_e'(wr_data[7:6]);
        dec = '0;
        if (wr_en) begin
            unique case (cmd)
                CMD_PTR: dec.ptr_ld = 1'b1;
                CMD_INK: dec.ink_ld = 1'b1;
                CMD_CFG: begin
                    dec.cfg_ld  = 1'b1;
                    dec.mode_ok = (wr_data[MODE_W-1:0] != MODE_BAD);
                    dec.div_clr = wr_data[4];
                end
                CMD_RSV: dec = '0;
            endcase
        end
    end
endmodule

// File: rtl/vid_palette_file.sv
module vid_palette_file #(
    parameter int INK_COUNT = 16,
    parameter int COLOUR_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ptr_ld,
    input  logic                         ink_ld,
    input  logic [7:0]                   data,
    input  logic [$clog2(INK_COUNT)-1:0] pix_ink,
    output logic [COLOUR_W-1:0]          pix_colour,
    output logic [COLOUR_W-1:0]          border_colour
);
    localparam int PTR_W = $clog2(INK_COUNT);

    logic [PTR_W:0]        ptr_q;
    logic [COLOUR_W-1:0]   border_q;
    logic [COLOUR_W-1:0]   ink_q [INK_COUNT];
    logic                  sel_border;

    assign sel_border = ptr_q[PTR_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            border_q <= '0;
        end else begin
            if (ptr_ld)
                ptr_q <= data[PTR_W:0];
            if (ink_ld && sel_border)
                border_q <= data[COLOUR_W-1:0];
        end
    end

    for (genvar i = 0; i < INK_COUNT; i++) begin : g_ink
        always_ff @(posedge clk) begin
            if (ink_ld && !sel_border && (ptr_q[PTR_W-1:0] == PTR_W'(i)))
                ink_q[i] <= data[COLOUR_W-1:0];
        end
    end

    assign pix_colour    = ink_q[pix_ink];
    assign border_colour = border_q;

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_ld |=> $stable(ptr_q));

    // R3
    border_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ink_ld && sel_border) |=> (border_q == $past(data[COLOUR_W-1:0])));

endmodule

// File: rtl/vid_mode_sync.sv
module vid_mode_sync
    import vid_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] new_mode,
    input  logic              hflyback,
    output logic [MODE_W-1:0] mode_q
);
    msync_e            state_q, state_d;
    logic [MODE_W-1:0] pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_IDLE: if (mode_wr) state_d = MS_PEND;
            MS_PEND: if (!mode_wr && hflyback) state_d = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mode_q <= '0;
        end else if (mode_wr) begin
            pend_q <= new_mode;
        end else if (state_q == MS_PEND && hflyback) begin
            mode_q <= pend_q;
        end
    end

    // R6
    mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> ($past(hflyback) && $past(state_q) == MS_PEND));

    // R7
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != MODE_BAD);

endmodule

// File: rtl/vid_rom_overlay.sv
module vid_rom_overlay #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rd,
    input  logic              ext_rom_off,
    input  logic              lo_en,
    input  logic              hi_en,
    output logic              rd_from_rom
);
    localparam logic [1:0] REG_LO = 2'b00;
    localparam logic [1:0] REG_HI = 2'b11;

    logic [1:0] region;

    always_comb begin
        region      = mem_addr[ADDR_W-1 -: 2];
        rd_from_rom = mem_rd && !ext_rom_off &&
                      ((region == REG_LO && lo_en) || (region == REG_HI && hi_en));
    end

    // R9
    rom_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_from_rom |-> mem_rd);

    // R10
    ext_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rom_off |-> !rd_from_rom);

endmodule

// File: rtl/vid_cmd_port.sv
module vid_cmd_port
    import vid_cmd_pkg::*;
#(
    parameter int INK_COUNT = 16,
    parameter int COLOUR_W  = 5,
    parameter int ADDR_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [7:0]                   wr_data,
    input  logic                         hflyback,
    input  logic [$clog2(INK_COUNT)-1:0] pix_ink,
    output logic [COLOUR_W-1:0]          pix_colour,
    output logic [COLOUR_W-1:0]          border_colour,
    output logic [MODE_W-1:0]            video_mode,
    input  logic [ADDR_W-1:0]            mem_addr,
    input  logic                         mem_rd,
    input  logic                         ext_rom_off,
    output logic                         rom_lo_en,
    output logic                         rom_hi_en,
    output logic                         rd_from_rom,
    output logic                         irq_div_clr
);
    wr_dec_t dec;
    logic    lo_dis_q, hi_dis_q, clr_q;

    vid_cmd_decode u_decode (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .dec     (dec)
    );

    vid_palette_file #(
        .INK_COUNT (INK_COUNT),
        .COLOUR_W  (COLOUR_W)
    ) u_palette (
        .clk           (clk),
        .rst_n         (rst_n),
        .ptr_ld        (dec.ptr_ld),
        .ink_ld        (dec.ink_ld),
        .data          (wr_data),
        .pix_ink       (pix_ink),
        .pix_colour    (pix_colour),
        .border_colour (border_colour)
    );

    vid_mode_sync u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (dec.cfg_ld && dec.mode_ok),
        .new_mode (wr_data[MODE_W-1:0]),
        .hflyback (hflyback),
        .mode_q   (video_mode)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_dis_q <= 1'b0;
            hi_dis_q <= 1'b0;
            clr_q    <= 1'b0;
        end else begin
            clr_q <= dec.div_clr;
            if (dec.cfg_ld) begin
                lo_dis_q <= wr_data[2];
                hi_dis_q <= wr_data[3];
            end
        end
    end

    assign rom_lo_en   = !lo_dis_q;
    assign rom_hi_en   = !hi_dis_q;
    assign irq_div_clr = clr_q;

    vid_rom_overlay #(
        .ADDR_W (ADDR_W)
    ) u_overlay (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .ext_rom_off (ext_rom_off),
        .lo_en       (rom_lo_en),
        .hi_en       (rom_hi_en),
        .rd_from_rom (rd_from_rom)
    );

    // R5
    div_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_div_clr |-> $past(wr_en && wr_data[7:6] == 2'b10 && wr_data[4]));

    // R4
    rom_en_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rom_lo_en) || !$stable(rom_hi_en)) |-> $past(wr_en && wr_data[7:6] == 2'b10));

endmodule

// File: tb/test_vid_cmd_port.sv
module test_vid_cmd_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic        hflyback;
    logic [3:0]  pix_ink;
    logic [4:0]  pix_colour, border_colour;
    logic [1:0]  video_mode;
    logic [15:0] mem_addr;
    logic        mem_rd, ext_rom_off;
    logic        rom_lo_en, rom_hi_en, rd_from_rom, irq_div_clr;

    always #10 clk = ~clk;

    vid_cmd_port i_vid_cmd_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .hflyback(hflyback), .pix_ink(pix_ink), .pix_colour(pix_colour),
        .border_colour(border_colour), .video_mode(video_mode),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .ext_rom_off(ext_rom_off),
        .rom_lo_en(rom_lo_en), .rom_hi_en(rom_hi_en),
        .rd_from_rom(rd_from_rom), .irq_div_clr(irq_div_clr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model
    logic [4:0]  m_ptr;
    logic [4:0]  m_ink [16];
    logic [15:0] m_ink_ok;
    logic [4:0]  m_border;
    logic        m_lo, m_hi, m_clr, m_pend;
    logic [1:0]  m_mode, m_pmode;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_rom(input logic [15:0] a, input logic rd,
                                     input logic ext, input logic lo, input logic hi);
        return rd && !ext && ((a[15:14] == 2'b00 && lo) || (a[15:14] == 2'b11 && hi));
    endfunction

    task automatic model_reset();
        m_ptr = '0; m_border = '0; m_lo = 1'b1; m_hi = 1'b1;
        m_clr = 1'b0; m_pend = 1'b0; m_mode = '0; m_pmode = '0; m_ink_ok = '0;
    endtask

    task automatic model_step(input logic w, input logic [7:0] d, input logic hf);
        logic mw;
        mw    = w && d[7:6] == 2'b10 && d[1:0] != 2'b11;
        m_clr = w && d[7:6] == 2'b10 && d[4];
        if (w) begin
            case (d[7:6])
                2'b00: m_ptr = d[4:0];
                2'b01: begin
                    if (m_ptr[4]) m_border = d[4:0];
                    else begin
                        m_ink[m_ptr[3:0]]    = d[4:0];
                        m_ink_ok[m_ptr[3:0]] = 1'b1;
                    end
                end
                2'b10: begin m_lo = !d[2]; m_hi = !d[3]; end
                default: ;
            endcase
        end
        if (mw) begin
            m_pmode = d[1:0];
            m_pend  = 1'b1;
        end else if (m_pend && hf) begin
            m_mode = m_pmode;
            m_pend = 1'b0;
        end
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic hf,
                        input logic [3:0] pi, input logic [15:0] a,
                        input logic rd, input logic ext);
        @(negedge clk);
        wr_en = w; wr_data = d; hflyback = hf; pix_ink = pi;
        mem_addr = a; mem_rd = rd; ext_rom_off = ext;
        model_step(w, d, hf);
        @(posedge clk);
        #5;
        chk("R6 mode", int'(video_mode), int'(m_mode));
        chk("R4 rom_lo_en", int'(rom_lo_en), int'(m_lo));
        chk("R4 rom_hi_en", int'(rom_hi_en), int'(m_hi));
        chk("R5 irq_div_clr", int'(irq_div_clr), int'(m_clr));
        chk("R3 border", int'(border_colour), int'(m_border));
        if (m_ink_ok[pi])
            chk("R3 ink", int'(pix_colour), int'(m_ink[pi]));
        chk("R9 R10 rd_from_rom", int'(rd_from_rom), int'(exp_rom(a, rd, ext, m_lo, m_hi)));
    endtask

    task automatic wr(input logic [7:0] d, input logic hf);
        step(1'b1, d, hf, m_ptr[3:0], 16'h8000, 1'b1, 1'b0);
    endtask

    task automatic idle(input logic hf);
        step(1'b0, 8'h00, hf, m_ptr[3:0], 16'h8000, 1'b1, 1'b0);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; hflyback = 1'b0;
        pix_ink = '0; mem_addr = '0; mem_rd = 1'b0; ext_rom_off = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R8 reset state
        chk("R8 mode", int'(video_mode), 0);
        chk("R8 rom_lo_en", int'(rom_lo_en), 1);
        chk("R8 rom_hi_en", int'(rom_hi_en), 1);
        chk("R8 border", int'(border_colour), 0);
        chk("R8 irq_div_clr", int'(irq_div_clr), 0);
        // R9: reads from both ROM halves, writes pass to RAM
        step(1'b0, 8'h00, 1'b0, 4'd0, 16'h0123, 1'b1, 1'b0);
        chk("R9 lower read", int'(rd_from_rom), 1);
        step(1'b0, 8'h00, 1'b0, 4'd0, 16'hC010, 1'b1, 1'b0);
        chk("R9 upper read", int'(rd_from_rom), 1);
        step(1'b0, 8'h00, 1'b0, 4'd0, 16'h0123, 1'b0, 1'b0);
        chk("R9 write to RAM", int'(rd_from_rom), 0);
        // R10 external disable
        step(1'b0, 8'h00, 1'b0, 4'd0, 16'hFFFF, 1'b1, 1'b1);
        chk("R10 ext off", int'(rd_from_rom), 0);
        // R8 pointer resets to ink 0: a colour write lands in ink 0
        wr(8'h40 | 8'h0B, 1'b0);
        chk("R8 ptr at ink0", int'(pix_colour), 11);
        // R2 R3: point at ink 5, two colour writes, no auto-increment
        wr(8'h05, 1'b0);
        wr(8'h40 | 8'h13, 1'b0);
        wr(8'h40 | 8'h07, 1'b0);
        step(1'b0, 8'h00, 1'b0, 4'd5, 16'h8000, 1'b0, 1'b0);
        chk("R2 no auto-increment ink5", int'(pix_colour), 7);
        // R2 border via bit 4, low bits ignored
        wr(8'h1F, 1'b0);
        wr(8'h40 | 8'h16, 1'b0);
        chk("R2 border selected", int'(border_colour), 22);
        step(1'b0, 8'h00, 1'b0, 4'd15, 16'h8000, 1'b0, 1'b0);
        // R1 reserved command: would look like a pointer/config write
        wr(8'hC5, 1'b1);
        wr(8'hDF, 1'b0);
        wr(8'h40 | 8'h01, 1'b0);
        chk("R1 reserved ignored, ptr still border", int'(border_colour), 1);
        chk("R1 reserved no rom change", int'(rom_lo_en), 1);
        // R6 deferral: mode 2 write, no flyback for several cycles
        wr(8'h82, 1'b0);
        repeat (4) idle(1'b0);
        chk("R6 mode held before flyback", int'(video_mode), 0);
        // rearm during pending, write coincides with flyback
        wr(8'h81, 1'b1);
        chk("R6 write at flyback does not commit", int'(video_mode), 0);
        idle(1'b1);
        chk("R6 rearm value committed", int'(video_mode), 1);
        // R7 illegal mode with ROM disables and clear
        wr(8'h9F, 1'b0);
        chk("R7 rom lo off", int'(rom_lo_en), 0);
        chk("R5 clear pulse", int'(irq_div_clr), 1);
        idle(1'b1);
        chk("R5 clear one cycle", int'(irq_div_clr), 0);
        chk("R7 mode unchanged", int'(video_mode), 1);
        // R4 upper half only disabled
        wr(8'h88 | 8'h01, 1'b0);
        step(1'b0, 8'h00, 1'b0, 4'd0, 16'h2000, 1'b1, 1'b0);
        chk("R4 lower on after re-enable", int'(rd_from_rom), 1);
        step(1'b0, 8'h00, 1'b0, 4'd0, 16'hE000, 1'b1, 1'b0);
        chk("R4 upper off", int'(rd_from_rom), 0);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] d;
            d = 8'($urandom);
            step(($urandom % 3) != 0, d, ($urandom % 9) == 0, 4'($urandom),
                 16'($urandom), 1'($urandom), ($urandom % 6) == 0);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule